// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial PCM stream into parallel sample pairs. It runs directly on the bit clock. On each rising bit clock edge it samples the serial data line and the frame clock. Every change of frame clock level starts a new half-frame, and each half-frame carries one channel. A two-bit format code picks one of four justification schemes. The code is captured only while reset is asserted, so a new format takes effect only through a reset.

Each completed left/right pair appears on two 24-bit signed output words together with a one-cycle strobe. The output side is a push-only stream and offers no back-pressure. The sink must take every strobed pair, because audio arrives at a fixed rate and cannot be paused. The words stay unchanged until the next strobe, which gives the sink a full frame period to read them.

Top module: `pcm_serial_rx`

## Requirements
- R1: Format code 2'b00 selects 16-bit right-justified data: the last 16 bits sampled before a frame clock change form the word, which is sign-extended to 24 bits; any bits earlier in the half-frame are discarded.
- R2: Format code 2'b01 selects 24-bit right-justified data: the last 24 bits sampled before a frame clock change form the word; any bits earlier in the half-frame are discarded.
- R3: Format code 2'b10 selects 24-bit left-justified data: the bit sampled on the first rising edge that sees the new frame clock level is the word's bit 23, followed by 23 more bits; later bits of the half-frame are discarded.
- R4: Format code 2'b11 selects the delayed (I2S-style) format: the word's bit 23 is sampled one bit clock after the first edge that sees the new level. A 24-bit half-frame yields all 24 bits. A 16-bit half-frame yields the word in bits 23:8 with bits 7:0 zero.
- R5: In codes 2'b00, 2'b01 and 2'b10 a high frame clock marks the left channel; in code 2'b11 a low frame clock marks the left channel.
- R6: Data is taken MSB first, in two's complement, sampled on the rising bit clock edge.
- R7: The strobe is high for exactly one cycle, namely the cycle after the edge on which a right word is completed, and only if a left word was completed since the previous strobe; both output words stay unchanged while the strobe is low.
- R8: The format code is sampled only while reset is asserted; a change on the format pins outside reset has no effect on decoding.
- R9: Reset is synchronous and active low; it clears both output words to zero and the strobe to low, and no word is formed from bits that precede the first frame clock change after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; format code captured while low |
| fmt_sel | input | 2 | Format code, see R1 to R4 |
| frame_clk | input | 1 | Frame clock; its level selects the channel |
| sdata | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample of the most recent pair |
| right_o | output | 24 | Right sample of the most recent pair |
| sample_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench puts junk bits in the unused slots of longer half-frames. A receiver that counted from the wrong end of the half-frame would then yield garbage in the right-justified modes, or would lose the leading bits in the left-justified mode. Negative 16-bit words show whether the sign extension works, and 16-bit words sent in the delayed format show whether the low byte is zero-filled and whether the last bit, which arrives with the frame clock change, is placed correctly. Left and right values always differ, so a swapped channel polarity in either mode shows up as a mismatch. The bench records the bit slot in which the strobe appears, so a one-cycle slip in the strobe shows up, and it flips the format pins after reset, so a design that followed those pins live would decode in the wrong format.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ24 = 2'b10,
    FMT_DLY  = 2'b11
  } fmt_e;

  // frame clock level that marks the left channel in a given format
  function automatic logic left_level(input fmt_e f);
    return (f != FMT_DLY);
  endfunction
endpackage

// File: rtl/pcm_rx_frame_edge.sv
module pcm_rx_frame_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lr,
  output logic tr,
  output logic lr_prev
);
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      lr_prev <= 1'b0;
    end else begin
      seen    <= 1'b1;
      lr_prev <= lr;
    end
  end

  // level change relative to the previous sampled level
  assign tr = seen && (lr != lr_prev);
endmodule

// File: rtl/pcm_rx_tail_path.sv
module pcm_rx_tail_path #(
  parameter int W       = 24,
  parameter int SHORT_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         short_word,
  input  logic         tr,
  input  logic         sd,
  input  logic         lr_prev,
  output logic         cv,
  output logic         clvl,
  output logic [W-1:0] cw
);
  logic [W-1:0] sr;
  logic         armed;
  logic [W-1:0] short_ext;

  generate
    if (SHORT_W < W) begin : g_ext
      assign short_ext = {{(W-SHORT_W){sr[SHORT_W-1]}}, sr[SHORT_W-1:0]};
    end else begin : g_noext
      assign short_ext = sr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr    <= '0;
      armed <= 1'b0;
    end else begin
      sr <= {sr[W-2:0], sd};
      if (en && tr) armed <= 1'b1;
    end
  end

  // the window holds the finished half-frame when the new level is seen
  assign cv   = en && tr && armed;
  assign clvl = lr_prev;
  assign cw   = short_word ? short_ext : sr;
endmodule

// File: rtl/pcm_rx_head_path.sv
module pcm_rx_head_path #(
  parameter int W = 24,
  localparam int NB_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         delayed,
  input  logic         tr,
  input  logic         sd,
  input  logic         lr,
  output logic         cv,
  output logic         clvl,
  output logic [W-1:0] cw
);
  logic            active;
  logic            done;
  logic [NB_W-1:0] nb;
  logic [W-1:0]    acc;
  logic            lvl;
  logic [W-1:0]    with_bit;
  logic [NB_W-1:0] pos;
  logic            last_bit;

  assign pos      = NB_W'(W - 1) - nb;
  assign last_bit = (nb == NB_W'(W - 1));

  always_comb begin
    with_bit = acc;
    if (nb < NB_W'(W)) with_bit[pos] = sd;
  end

  always_comb begin
    cv = 1'b0;
    cw = acc;
    if (en && active && !done) begin
      if (tr) begin
        // half-frame cut short: in the delayed format this edge still
        // carries the old word's final bit
        cv = (nb != '0);
        cw = delayed ? with_bit : acc;
      end else if (last_bit) begin
        cv = 1'b1;
        cw = with_bit;
      end
    end
  end

  assign clvl = lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      nb     <= '0;
      acc    <= '0;
      lvl    <= 1'b0;
    end else if (en) begin
      if (tr) begin
        active <= 1'b1;
        done   <= 1'b0;
        lvl    <= lr;
        if (delayed) begin
          nb  <= '0;
          acc <= '0;
        end else begin
          nb  <= NB_W'(1);
          acc <= {sd, {(W-1){1'b0}}};
        end
      end else if (active && !done) begin
        acc <= with_bit;
        nb  <= nb + 1'b1;
        if (last_bit) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_rx_pairer.sv
module pcm_rx_pairer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cv,
  input  logic         cleft,
  input  logic [W-1:0] cw,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  logic [W-1:0] left_hold;
  logic         have_left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cv && cleft) begin
        left_hold <= cw;
        have_left <= 1'b1;
      end else if (cv && have_left) begin
        left_o    <= left_hold;
        right_o   <= cw;
        valid_o   <= 1'b1;
        have_left <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  input  logic              frame_clk,
  input  logic              sdata,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              sample_valid
);
  import pcm_rx_pkg::*;

  fmt_e              fmt_q;
  logic              tr, lr_prev;
  logic              en_tail, en_head;
  logic              tail_cv, tail_lvl, head_cv, head_lvl;
  logic [WORD_W-1:0] tail_cw, head_cw;
  logic              cv, cleft, clvl;
  logic [WORD_W-1:0] cw;

  always_ff @(posedge bclk) begin
    if (!rst_n) fmt_q <= fmt_e'(fmt_sel);
  end

  assign en_tail = (fmt_q == FMT_RJ16) || (fmt_q == FMT_RJ24);
  assign en_head = !en_tail;

  pcm_rx_frame_edge u_edge (
    .clk(bclk), .rst_n(rst_n), .lr(frame_clk), .tr(tr), .lr_prev(lr_prev)
  );

  pcm_rx_tail_path #(.W(WORD_W), .SHORT_W(SHORT_W)) u_tail (
    .clk(bclk), .rst_n(rst_n), .en(en_tail), .short_word(fmt_q == FMT_RJ16),
    .tr(tr), .sd(sdata), .lr_prev(lr_prev),
    .cv(tail_cv), .clvl(tail_lvl), .cw(tail_cw)
  );

  pcm_rx_head_path #(.W(WORD_W)) u_head (
    .clk(bclk), .rst_n(rst_n), .en(en_head), .delayed(fmt_q == FMT_DLY),
    .tr(tr), .sd(sdata), .lr(frame_clk),
    .cv(head_cv), .clvl(head_lvl), .cw(head_cw)
  );

  assign cv    = tail_cv || head_cv;
  assign cw    = tail_cv ? tail_cw : head_cw;
  assign clvl  = tail_cv ? tail_lvl : head_lvl;
  assign cleft = (clvl == left_level(fmt_q));

  pcm_rx_pairer #(.W(WORD_W)) u_pair (
    .clk(bclk), .rst_n(rst_n), .cv(cv), .cleft(cleft), .cw(cw),
    .left_o(left_o), .right_o(right_o), .valid_o(sample_valid)
  );
endmodule

// File: rtl/pcm_serial_rx_chk.sv
module pcm_serial_rx_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   fmt_q,
  input logic         valid,
  input logic [W-1:0] left,
  input logic [W-1:0] right,
  input logic         cv,
  input logic         cleft,
  input logic         tail_cv,
  input logic         head_cv
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r7_after_right: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(cv && !cleft));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !valid) |-> ($stable(left) && $stable(right)));

  a_r8_fmt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(fmt_q));

  a_r9_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!valid && left == '0 && right == '0));

  a_r1_one_path: assert property (@(posedge clk) disable iff (!rst_n)
    !(tail_cv && head_cv));
endmodule

bind pcm_serial_rx pcm_serial_rx_chk #(.W(WORD_W)) u_chk (
  .clk(bclk), .rst_n(rst_n), .fmt_q(fmt_q), .valid(sample_valid),
  .left(left_o), .right(right_o), .cv(cv), .cleft(cleft),
  .tail_cv(tail_cv), .head_cv(head_cv)
);

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        frame_clk = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        sample_valid;

  int checks = 0;
  int fails = 0;
  int cur_g = 0;
  int first_strobe = -1;
  logic prev_v = 1'b0;
  bit done_flag = 0;

  logic        bq[$];
  logic        lq[$];
  logic [47:0] exp_q[$];
  string       tag_q[$];

  always #2 bclk = ~bclk;

  pcm_serial_rx u_dut (
    .bclk(bclk), .rst_n(rst_n), .fmt_sel(fmt_sel), .frame_clk(frame_clk),
    .sdata(sdata), .left_o(left_o), .right_o(right_o),
    .sample_valid(sample_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [47:0] got,
                       input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic lvl_left(input int f);
    return (f == 3) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic [23:0] exp_word(input int f, input int n,
                                           input logic [23:0] w);
    case (f)
      0: return {{8{w[15]}}, w[15:0]};
      3: return (n < 24) ? {w[23:8], 8'h00} : w;
      default: return w;
    endcase
  endfunction

  task automatic add_slot(input logic lv, input logic b);
    bq.push_back(b);
    lq.push_back(lv);
  endtask

  task automatic add_half(input int f, input int n, input logic lv,
                          input logic [23:0] w);
    for (int s = 0; s < n; s++) begin
      logic b;
      case (f)
        0: b = (s >= n - 16) ? w[15 - (s - (n - 16))] : ~s[0];
        1: b = (s >= n - 24) ? w[23 - (s - (n - 24))] : ~s[0];
        2: b = (s < 24) ? w[23 - s] : ~s[0];
        default: b = (s < 24) ? w[23 - s] : 1'b0;
      endcase
      add_slot(lv, b);
    end
  endtask

  task automatic add_frame(input int f, input int n, input logic [23:0] l,
                           input logic [23:0] r, input string tag);
    add_half(f, n, lvl_left(f), l);
    add_half(f, n, ~lvl_left(f), r);
    exp_q.push_back({exp_word(f, n, l), exp_word(f, n, r)});
    tag_q.push_back(tag);
  endtask

  // reset with format code f, then leave fmt_pins on the pins
  task automatic start_stream(input int f, input logic [1:0] fmt_pins);
    @(negedge bclk);
    rst_n = 1'b0;
    fmt_sel = 2'(f);
    frame_clk = ~lvl_left(f);
    sdata = 1'b0;
    repeat (4) @(negedge bclk);
    // R9: outputs cleared and strobe low under reset
    check(left_o == 24'h0 && right_o == 24'h0 && !sample_valid,
          "R9 reset state", {left_o, right_o}, 48'h0);
    rst_n = 1'b1;
    fmt_sel = fmt_pins;
    for (int i = 0; i < 4; i++) add_slot(~lvl_left(f), 1'b0);
  endtask

  task automatic play(input int f, input int n);
    add_half(f, n, lvl_left(f), 24'h0);
    first_strobe = -1;
    for (int g = 0; g < bq.size(); g++) begin
      @(negedge bclk);
      frame_clk = (f == 3 && g + 1 < lq.size()) ? lq[g + 1] : lq[g];
      sdata = bq[g];
      cur_g = g;
    end
    repeat (4) @(negedge bclk);
    check(exp_q.size() == 0, "R7 strobe count", 48'(exp_q.size()), 48'h0);
    exp_q.delete();
    tag_q.delete();
    bq.delete();
    lq.delete();
  endtask

  always @(posedge bclk) begin
    #1;
    if (rst_n) begin
      if (sample_valid) begin
        if (first_strobe < 0) first_strobe = cur_g;
        if (prev_v) check(1'b0, "R7 strobe longer than one cycle", 48'h1, 48'h0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", {left_o, right_o}, 48'h0);
        end else begin
          logic [47:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({left_o, right_o} == e, t, {left_o, right_o}, e);
        end
      end
      prev_v = sample_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge bclk);
    check(1'b0, "watchdog expired", 48'h0, 48'h1);
    finish_up();
  end

  initial begin
    // R1 R6: 16-bit right-justified, 16-slot halves, negative values
    start_stream(0, 2'b00);
    add_frame(0, 16, 24'h001234, 24'h00ABCD, "R1 R6 rj16 mixed sign");
    add_frame(0, 16, 24'h008001, 24'h007FFF, "R1 sign extension");
    play(0, 16);

    // R1: 24-slot halves, leading junk must be dropped
    start_stream(0, 2'b00);
    add_frame(0, 24, 24'h00F00F, 24'h000123, "R1 rj16 in 24-slot halves");
    play(0, 24);

    // R2 R5: 24-bit right-justified, strobe slot timing
    start_stream(1, 2'b01);
    add_frame(1, 24, 24'h123456, 24'hFEDCBA, "R2 R5 rj24 channels");
    add_frame(1, 24, 24'h800000, 24'h7FFFFF, "R2 R6 rj24 extremes");
    play(1, 24);
    check(first_strobe == 52, "R7 rj24 strobe slot", 48'(first_strobe), 48'd52);

    start_stream(1, 2'b01);
    add_frame(1, 32, 24'hA5A5A5, 24'h5A5A5A, "R2 rj24 in 32-slot halves");
    play(1, 32);

    // R3: left-justified, strobe right after the 24th right bit
    start_stream(2, 2'b10);
    add_frame(2, 24, 24'hC0FFEE, 24'h0BADF0, "R3 R5 lj24 channels");
    play(2, 24);
    check(first_strobe == 51, "R3 R7 lj24 strobe slot", 48'(first_strobe), 48'd51);

    start_stream(2, 2'b10);
    add_frame(2, 32, 24'h13579B, 24'hECA864, "R3 lj24 trailing junk");
    play(2, 32);

    // R4: delayed format, 16-bit and 24-bit halves
    start_stream(3, 2'b11);
    add_frame(3, 16, 24'hBEEF00, 24'h1234FF, "R4 R5 delayed 16-bit");
    add_frame(3, 16, 24'h7FFF00, 24'h800100, "R4 delayed 16-bit extremes");
    play(3, 16);

    start_stream(3, 2'b11);
    add_frame(3, 24, 24'h876543, 24'h2468AC, "R4 delayed 24-bit");
    play(3, 24);
    check(first_strobe == 51, "R4 R7 delayed strobe slot", 48'(first_strobe), 48'd51);

    // R8: pins flipped after reset, decoding stays left-justified
    start_stream(2, 2'b00);
    add_frame(2, 24, 24'h314159, 24'h271828, "R8 format pins ignored");
    play(2, 24);

    finish_up();
  end
endmodule